// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with PWM Output

This block is a general-purpose timer that runs on the system clock. A prescale counter divides the clock so that the main counter takes one step every PRESCALE+1 clocks. The main counter counts up from zero to a reload limit and includes that limit. On the next step it returns to zero and produces an update event. The update event sets a sticky status flag. While the interrupt enable is on, that flag drives an interrupt request line.

A compare value shapes one PWM output. The output is high while the counter is below the compare value. The reload and compare values are written into holding registers. They move into the active copies only at an update event, so a period that has already started keeps the values it started with. Software configures and observes the timer through a small word-addressed register bus with combinational read data.

Top module: `prescaled_pwm_timer`

## Requirements
- R1: While counting is enabled, the counter advances once every PRESCALE+1 clocks. The interval between two update events is (PRESCALE+1)*(RELOAD+1) clocks, for example 8400 clocks for PRESCALE=83 and RELOAD=99.
- R2: The counter steps from 0 to RELOAD inclusive. On the step after RELOAD it returns to 0, and that step is an update event.
- R3: An update event sets the flag at status bit 0. irqOut is high exactly while that flag is set and control bit 1 (interrupt enable) is 1.
- R4: The flag stays set until the bus writes status with bit 0 equal to 0. Writing status with bit 0 equal to 1 leaves the flag unchanged. When an update event and a clearing write fall on the same edge, the flag ends up set.
- R5: pwmOut is high while the counter is below the active compare value and low otherwise. Over one period it is high for COMPARE*(PRESCALE+1) clocks.
- R6: When the compare value is greater than RELOAD, pwmOut stays high at all times. When the compare value is 0, pwmOut stays low at all times.
- R7: A write to the reload or compare register has no effect on counting or on pwmOut until the next update event. At that event the written value becomes active.
- R8: Counting runs only while control bit 0 (count enable) is 1. Clearing that bit holds both the prescale counter and the main counter at their current values.
- R9: After reset, every register and counter is 0 and pwmOut and irqOut are low.
- R10: The register word addresses are 0 prescale, 1 reload, 2 compare, 3 control, 4 status and 5 counter. The counter register is read-only. A read returns the value last written, or the current count, zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | 3 | Register word address |
| busWdata | input | BUS_W (16) | Write data |
| busRdata | output | BUS_W (16) | Read data for busAddr, combinational |
| pwmOut | output | 1 | PWM output |
| irqOut | output | 1 | Interrupt request, level |

## Verification
Some rules can be checked on every cycle. The assertions cover these: the counter never passes the active reload limit, the counter returns to zero after an update, the counter stays still while counting is disabled, and the active reload and compare copies change only at an update. They also cover the flag's set and hold rules and the two fixed compare cases for pwmOut. Other behaviour only shows over a whole run, so the bench's scenarios cover it. These are the period length for several prescale and reload pairs, the number of high clocks of pwmOut per period, the moment a written reload or compare value takes effect, and the register read-back.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_PRESCALE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_COMPARE  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CONTROL  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_COUNTER  = 3'd5;

  localparam int CTL_RUN_BIT = 0;
  localparam int CTL_IRQ_BIT = 1;
  localparam int STS_UPD_BIT = 0;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic wrPrescale;
    logic wrReload;
    logic wrCompare;
  } tmrStrobes_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import timer_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              updateEvt,
  output tmrStrobes_t       strobes,
  output logic              runEn,
  output logic              irqEn,
  output logic              updFlag,
  output logic              irqOut
);

  logic wrControl;
  logic wrStatus;
  logic clearReq;

  assign wrControl = busWe && (busAddr == ADDR_CONTROL);
  assign wrStatus  = busWe && (busAddr == ADDR_STATUS);
  assign clearReq  = wrStatus && !busWdata[STS_UPD_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn <= 1'b0;
      irqEn <= 1'b0;
    end else if (wrControl) begin
      runEn <= busWdata[CTL_RUN_BIT];
      irqEn <= busWdata[CTL_IRQ_BIT];
    end
  end

  // set has priority over a clearing write on the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      updFlag <= 1'b0;
    end else if (updateEvt) begin
      updFlag <= 1'b1;
    end else if (clearReq) begin
      updFlag <= 1'b0;
    end
  end

  always_comb begin
    strobes.countEn    = runEn;
    strobes.wrPrescale = busWe && (busAddr == ADDR_PRESCALE);
    strobes.wrReload   = busWe && (busAddr == ADDR_RELOAD);
    strobes.wrCompare  = busWe && (busAddr == ADDR_COMPARE);
  end

  assign irqOut = updFlag && irqEn;

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  input  logic [BUS_W-1:0] wrData,
  output logic [PSC_W-1:0] prescaleVal,
  output logic [CNT_W-1:0] reloadPre,
  output logic [CNT_W-1:0] comparePre,
  output logic [CNT_W-1:0] reloadAct,
  output logic [CNT_W-1:0] compareAct,
  output logic [CNT_W-1:0] cntVal,
  output logic             updateEvt,
  output logic             pwmOut
);

  logic [PSC_W-1:0] pscCnt;
  logic             tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescaleVal <= '0;
      reloadPre   <= '0;
      comparePre  <= '0;
    end else begin
      if (strobes.wrPrescale) prescaleVal <= wrData[PSC_W-1:0];
      if (strobes.wrReload)   reloadPre   <= wrData[CNT_W-1:0];
      if (strobes.wrCompare)  comparePre  <= wrData[CNT_W-1:0];
    end
  end

  // >= keeps the divider bounded if the limit drops mid-run
  assign tick      = strobes.countEn && (pscCnt >= prescaleVal);
  assign updateEvt = tick && (cntVal >= reloadAct);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (strobes.countEn) begin
      pscCnt <= tick ? '0 : pscCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (tick) begin
      cntVal <= updateEvt ? '0 : cntVal + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadAct  <= '0;
      compareAct <= '0;
    end else if (updateEvt) begin
      reloadAct  <= reloadPre;
      compareAct <= comparePre;
    end
  end

  assign pwmOut = cntVal < compareAct;

endmodule

// File: rtl/prescaled_pwm_timer.sv
module prescaled_pwm_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int BUS_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              pwmOut,
  output logic              irqOut
);

  tmrStrobes_t      strobes;
  logic             runEn;
  logic             irqEn;
  logic             updFlag;
  logic             updateEvt;
  logic [PSC_W-1:0] prescaleVal;
  logic [CNT_W-1:0] reloadPre;
  logic [CNT_W-1:0] comparePre;
  logic [CNT_W-1:0] reloadAct;
  logic [CNT_W-1:0] compareAct;
  logic [CNT_W-1:0] cntVal;

  tmr_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .updateEvt(updateEvt),
    .strobes  (strobes),
    .runEn    (runEn),
    .irqEn    (irqEn),
    .updFlag  (updFlag),
    .irqOut   (irqOut)
  );

  tmr_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W), .BUS_W(BUS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (busWdata),
    .prescaleVal(prescaleVal),
    .reloadPre  (reloadPre),
    .comparePre (comparePre),
    .reloadAct  (reloadAct),
    .compareAct (compareAct),
    .cntVal     (cntVal),
    .updateEvt  (updateEvt),
    .pwmOut     (pwmOut)
  );

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_PRESCALE: busRdata[PSC_W-1:0] = prescaleVal;
      ADDR_RELOAD:   busRdata[CNT_W-1:0] = reloadPre;
      ADDR_COMPARE:  busRdata[CNT_W-1:0] = comparePre;
      ADDR_CONTROL: begin
        busRdata[CTL_RUN_BIT] = runEn;
        busRdata[CTL_IRQ_BIT] = irqEn;
      end
      ADDR_STATUS:   busRdata[STS_UPD_BIT] = updFlag;
      ADDR_COUNTER:  busRdata[CNT_W-1:0] = cntVal;
      default:       busRdata = '0;
    endcase
  end

endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BUS_W-1:0]  busWdata,
  input logic              updateEvt,
  input logic              updFlag,
  input logic              irqEn,
  input logic              runEn,
  input logic              irqOut,
  input logic              pwmOut,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  reloadAct,
  input logic [CNT_W-1:0]  compareAct
);

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntVal <= reloadAct);

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    updateEvt |=> (cntVal == '0));

  assert_update_sets_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    updateEvt |=> updFlag);

  assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (updateEvt && irqEn && !(busWe && busAddr == ADDR_CONTROL)) |=> irqOut);

  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (updFlag && !(busWe && busAddr == ADDR_STATUS && !busWdata[STS_UPD_BIT])) |=> updFlag);

  assert_pwm_high_above_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (compareAct > reloadAct) |-> pwmOut);

  assert_pwm_low_zero_compare_R6: assert property (@(posedge clk) disable iff (!rstN)
    (compareAct == '0) |-> !pwmOut);

  assert_shadow_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !updateEvt |=> ($stable(reloadAct) && $stable(compareAct)));

  assert_frozen_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(cntVal));

  assert_no_update_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !updateEvt);

endmodule

bind prescaled_pwm_timer timer_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .updateEvt (updateEvt),
  .updFlag   (updFlag),
  .irqEn     (irqEn),
  .runEn     (runEn),
  .irqOut    (irqOut),
  .pwmOut    (pwmOut),
  .cntVal    (cntVal),
  .reloadAct (reloadAct),
  .compareAct(compareAct)
);

// File: tb/prescaled_pwm_timer_tb.sv
module prescaled_pwm_timer_tb;

  localparam int BUS_W = 16;
  localparam logic [2:0] A_PSC = 3'd0;
  localparam logic [2:0] A_RLD = 3'd1;
  localparam logic [2:0] A_CMP = 3'd2;
  localparam logic [2:0] A_CTL = 3'd3;
  localparam logic [2:0] A_STS = 3'd4;
  localparam logic [2:0] A_CNT = 3'd5;
  localparam int WATCHDOG = 190000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busWe = 1'b0;
  logic [2:0]       busAddr = '0;
  logic [BUS_W-1:0] busWdata = '0;
  logic [BUS_W-1:0] busRdata;
  logic             pwmOut;
  logic             irqOut;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prescaled_pwm_timer u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut), .irqOut(irqOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [BUS_W-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  // clears the flag, waits for the next update, clears again; needs irq enabled
  task automatic waitUpdate();
    writeReg(A_STS, '0);
    do @(negedge clk); while (!irqOut);
    writeReg(A_STS, '0);
  endtask

  task automatic measurePeriod(input int expClk, input string req);
    int n;
    writeReg(A_STS, '0);
    do @(negedge clk); while (!irqOut);
    busWe = 1'b1; busAddr = A_STS; busWdata = '0;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) busWe = 1'b0;
      if (irqOut && n > 1) break;
    end
    check(n == expClk, req, n, expClk);
  endtask

  task automatic countHigh(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
  endtask

  task automatic testReset();
    logic [BUS_W-1:0] v;
    for (int a = 0; a < 6; a++) begin
      readReg(a[2:0], v);
      check(v == '0, "R9 reset register", v, 0);
    end
    check(pwmOut == 1'b0, "R9 reset pwm", pwmOut, 0);
    check(irqOut == 1'b0, "R9 reset irq", irqOut, 0);
  endtask

  task automatic testRegMap();
    logic [BUS_W-1:0] v;
    writeReg(A_PSC, 16'd5);
    writeReg(A_RLD, 16'd7);
    writeReg(A_CMP, 16'd3);
    writeReg(A_CTL, 16'd2);
    writeReg(A_CNT, 16'h00AB);
    readReg(A_PSC, v); check(v == 16'd5, "R10 prescale readback", v, 5);
    readReg(A_RLD, v); check(v == 16'd7, "R10 reload readback", v, 7);
    readReg(A_CMP, v); check(v == 16'd3, "R10 compare readback", v, 3);
    readReg(A_CTL, v); check(v == 16'd2, "R10 control readback", v, 2);
    readReg(A_CNT, v); check(v == 16'd0, "R10 counter read-only", v, 0);
  endtask

  task automatic testFlag();
    logic [BUS_W-1:0] v;
    writeReg(A_PSC, 16'd0);
    writeReg(A_CTL, 16'd1);
    repeat (3) @(negedge clk);
    writeReg(A_CTL, 16'd0);
    readReg(A_STS, v); check(v[0] == 1'b1, "R3 update sets flag", v[0], 1);
    check(irqOut == 1'b0, "R3 irq masked", irqOut, 0);
    writeReg(A_STS, 16'd1);
    readReg(A_STS, v); check(v[0] == 1'b1, "R4 write one keeps flag", v[0], 1);
    writeReg(A_CTL, 16'd2);
    #1; check(irqOut == 1'b1, "R3 irq enabled", irqOut, 1);
    writeReg(A_STS, 16'd0);
    readReg(A_STS, v); check(v[0] == 1'b0, "R4 write zero clears", v[0], 0);
    check(irqOut == 1'b0, "R3 irq drops with flag", irqOut, 0);
  endtask

  task automatic testFreeze();
    logic [BUS_W-1:0] a, b, c;
    writeReg(A_CTL, 16'd3);
    repeat (13) @(negedge clk);
    writeReg(A_CTL, 16'd2);
    readReg(A_CNT, a);
    repeat (20) @(negedge clk);
    readReg(A_CNT, b);
    check(a == b, "R8 counter frozen", b, a);
    writeReg(A_CTL, 16'd3);
    repeat (20) @(negedge clk);
    readReg(A_CNT, c);
    check(c != a, "R8 counter resumes", c, a);
  endtask

  task automatic testPeriods();
    writeReg(A_PSC, 16'd0);  writeReg(A_RLD, 16'd9);
    measurePeriod(10, "R2 period reload 9");
    writeReg(A_PSC, 16'd2);  writeReg(A_RLD, 16'd4);
    measurePeriod(15, "R1 period psc 2 reload 4");
    writeReg(A_PSC, 16'd83); writeReg(A_RLD, 16'd99);
    measurePeriod(8400, "R1 period psc 83 reload 99");
  endtask

  task automatic testPwm();
    int hi;
    writeReg(A_PSC, 16'd0); writeReg(A_RLD, 16'd9); writeReg(A_CMP, 16'd3);
    waitUpdate(); waitUpdate();
    countHigh(10, hi); check(hi == 3, "R5 duty 3 of 10", hi, 3);
    writeReg(A_PSC, 16'd1); writeReg(A_CMP, 16'd7);
    waitUpdate(); waitUpdate();
    countHigh(20, hi); check(hi == 14, "R5 duty 7 of 10 with psc 1", hi, 14);
    writeReg(A_PSC, 16'd0); writeReg(A_CMP, 16'd0);
    waitUpdate(); waitUpdate();
    countHigh(20, hi); check(hi == 0, "R6 compare zero low", hi, 0);
    writeReg(A_CMP, 16'd15);
    waitUpdate(); waitUpdate();
    countHigh(20, hi); check(hi == 20, "R6 compare above reload high", hi, 20);
  endtask

  task automatic testShadow();
    logic [BUS_W-1:0] v;
    int hi;
    writeReg(A_RLD, 16'd49); writeReg(A_CMP, 16'd40);
    waitUpdate(); waitUpdate();
    writeReg(A_CMP, 16'd5);
    writeReg(A_RLD, 16'd4);
    repeat (4) @(negedge clk);
    check(pwmOut == 1'b1, "R7 old compare still active", pwmOut, 1);
    readReg(A_CNT, v);
    check(v > 16'd4, "R7 old reload still active", v, 5);
    measurePeriod(5, "R7 new reload after update");
    countHigh(5, hi); check(hi == 5, "R7 new compare after update", hi, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegMap();
    testFlag();
    testFreeze();
    testPeriods();
    testPwm();
    testShadow();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule